// File: doc/BRIEF.md
# Infrared Carrier Waveform Generator

This block produces the modulation carrier that drives an infrared remote-control LED. It runs from the system clock, which is nominally 455 kHz. Software picks the carrier in one of two ways. It can choose one of three fixed presets through a two-bit format field. It can instead switch to a programmable mode, where each overflow of an 8-bit reloadable timer flips the output. A separate enable flag turns the carrier on and off. While that flag is low, both engines are held at their starting point, so every burst opens with a pulse of full width.

The presets come from dividing the clock. Dividing by 12 gives 38 kHz, with either 4 or 6 clocks high. Dividing by 8 gives 57 kHz, with 4 clocks high. A change of preset is held back until the running period ends, so no period is clipped. In timer mode the 8-bit counter counts up from the programmed reload value. When it wraps past all-ones it reloads and the output flips. Each half period is therefore 256 minus the reload value clocks long, which covers roughly 1 kHz to 200 kHz.

Top module: `ir_carrier_gen`

## Requirements
- R1: While reset is asserted and after it is released with the enable low, `carrier_out` is 0.
- R2: With `tmr_mode`=0 and `fmt_sel`=2'b00 the output repeats 4 clocks high followed by 8 clocks low (38 kHz, one-third duty).
- R3: With `tmr_mode`=0 and `fmt_sel`=2'b01 the output repeats 6 clocks high followed by 6 clocks low (38 kHz, one-half duty).
- R4: With `tmr_mode`=0 and `fmt_sel`=2'b10 the output repeats 4 clocks high followed by 4 clocks low (57 kHz, one-half duty).
- R5: With `tmr_mode`=0 and `fmt_sel`=2'b11 (reserved) the output stays 0 while enabled.
- R6: Dropping `carrier_en` forces `carrier_out` to 0 in the same cycle. After the enable rises again, the output goes high at the first clock edge and the first pulse has full width.
- R7: A change of `fmt_sel` in the middle of a preset period leaves that period unchanged. The new preset applies from the next period start.
- R8: With `tmr_mode`=1 the output starts low on enable and toggles every 256-`tmr_reload` enabled clocks. The reload value is captured at each wrap.
- R9: With `tmr_mode`=1 the value of `fmt_sel` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 455 kHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Preset select: 00 38k/third, 01 38k/half, 10 57k/half, 11 off |
| carrier_en | input | 1 | Carrier on/off flag |
| tmr_mode | input | 1 | 1 selects the timer-overflow carrier instead of a preset |
| tmr_reload | input | 8 | Reload value for the timer |
| carrier_out | output | 1 | Carrier pin drive |

## Verification
Each preset is run long enough to measure a full high and low phase. The measured widths separate the one-third and one-half duty ratios, and they also separate the divide-by-12 and divide-by-8 periods. The preset is switched in the middle of a period, which shows whether the change waits for the period boundary. The enable is dropped while the output is high, which shows that the output falls in the same cycle and that the next burst restarts cleanly. Timer mode is tried with two reload values and with a preset select that should be ignored. That checks the half-period length, the low starting level and the capture of the reload value at the wrap.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;

   typedef enum logic [1:0] {
      FMT_38_THIRD = 2'b00,
      FMT_38_HALF  = 2'b01,
      FMT_57_HALF  = 2'b10,
      FMT_OFF      = 2'b11
   } carrier_fmt_e;

   function automatic int unsigned clog2_min1(input int unsigned v);
      int unsigned r;
      r = 1;
      while ((1 << r) < v) r++;
      return r;
   endfunction

endpackage

// File: rtl/ir_preset_div.sv
module ir_preset_div
   import ir_carrier_pkg::*;
#(
   parameter int unsigned DIV_38  = 12,
   parameter int unsigned HI_38_T = 4,
   parameter int unsigned HI_38_H = 6,
   parameter int unsigned DIV_57  = 8,
   parameter int unsigned HI_57   = 4,
   parameter int unsigned CNT_W   = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [1:0] fmt_i,
   output logic       wave_o
);

   localparam int unsigned MAX_DIV = (DIV_38 > DIV_57) ? DIV_38 : DIV_57;

   carrier_fmt_e           cur_q, eff;
   logic [CNT_W-1:0]       cnt_q;
   logic [CNT_W-1:0]       last_ph;
   logic [CNT_W-1:0]       hi_len;
   logic                   wave_q;

   // A new format is only accepted at phase zero
   always_comb begin
      eff = (cnt_q == '0) ? carrier_fmt_e'(fmt_i) : cur_q;
      unique case (eff)
         FMT_38_THIRD: begin last_ph = CNT_W'(DIV_38 - 1); hi_len = CNT_W'(HI_38_T); end
         FMT_38_HALF:  begin last_ph = CNT_W'(DIV_38 - 1); hi_len = CNT_W'(HI_38_H); end
         FMT_57_HALF:  begin last_ph = CNT_W'(DIV_57 - 1); hi_len = CNT_W'(HI_57);   end
         default:      begin last_ph = CNT_W'(DIV_57 - 1); hi_len = '0;             end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         cur_q  <= FMT_38_THIRD;
         wave_q <= 1'b0;
      end else if (!en) begin
         cnt_q  <= '0;
         wave_q <= 1'b0;
      end else begin
         cur_q  <= eff;
         wave_q <= (cnt_q < hi_len);
         cnt_q  <= (cnt_q == last_ph) ? '0 : cnt_q + 1'b1;
      end
   end

   assign wave_o = wave_q;

   // R6: disabled engine parks at phase zero with a low output
   assert_park_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0) && !wave_q);

   // R7: latched format can only change after a phase-zero cycle
   assert_fmt_held_mid_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt_q != '0) |=> (cur_q == $past(cur_q)));

   // R2: phase never leaves the longest period
   assert_phase_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (cnt_q < CNT_W'(MAX_DIV)));

endmodule

// File: rtl/ir_timer_div.sv
module ir_timer_div #(
   parameter int unsigned TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [TMR_W-1:0] reload_i,
   output logic             wave_o
);

   localparam logic [TMR_W-1:0] TOP = '1;

   logic [TMR_W-1:0] tcnt_q;
   logic             tog_q;
   logic             wrap;

   assign wrap = (tcnt_q == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt_q <= '0;
         tog_q  <= 1'b0;
      end else if (!en) begin
         tcnt_q <= reload_i;
         tog_q  <= 1'b0;
      end else if (wrap) begin
         tcnt_q <= reload_i;
         tog_q  <= ~tog_q;
      end else begin
         tcnt_q <= tcnt_q + 1'b1;
      end
   end

   assign wave_o = tog_q;

   // R8: level only changes on a wrap while enabled
   assert_hold_between_wraps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tcnt_q != TOP) |=> (tog_q == $past(tog_q)) && (tcnt_q == $past(tcnt_q) + 1'b1));

   // R8: every wrap flips the level and reloads
   assert_flip_on_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tcnt_q == TOP) |=> (tog_q != $past(tog_q)) && (tcnt_q == $past(reload_i)));

   // R8: burst starts low
   assert_start_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !tog_q);

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
   import ir_carrier_pkg::*;
#(
   parameter int unsigned DIV_38  = 12,
   parameter int unsigned HI_38_T = 4,
   parameter int unsigned HI_38_H = 6,
   parameter int unsigned DIV_57  = 8,
   parameter int unsigned HI_57   = 4,
   parameter int unsigned TMR_W   = 8,
   parameter bit          HAS_TMR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       fmt_sel,
   input  logic             carrier_en,
   input  logic             tmr_mode,
   input  logic [TMR_W-1:0] tmr_reload,
   output logic             carrier_out
);

   localparam int unsigned MAX_DIV = (DIV_38 > DIV_57) ? DIV_38 : DIV_57;
   localparam int unsigned CNT_W   = clog2_min1(MAX_DIV);

   generate
      if (HI_38_T == 0 || HI_38_T >= DIV_38 || HI_38_H >= DIV_38 || HI_57 >= DIV_57) begin : g_bad_duty
         $error("ir_carrier_gen: high phase must be shorter than its period");
      end
      if (TMR_W < 2) begin : g_bad_tmr
         $error("ir_carrier_gen: timer width too small");
      end
   endgenerate

   logic preset_wave;
   logic timer_wave;

   ir_preset_div #(
      .DIV_38 (DIV_38), .HI_38_T(HI_38_T), .HI_38_H(HI_38_H),
      .DIV_57 (DIV_57), .HI_57  (HI_57),   .CNT_W  (CNT_W)
   ) u_preset (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (carrier_en),
      .fmt_i  (fmt_sel),
      .wave_o (preset_wave)
   );

   generate
      if (HAS_TMR) begin : g_tmr
         ir_timer_div #(.TMR_W(TMR_W)) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (carrier_en),
            .reload_i (tmr_reload),
            .wave_o   (timer_wave)
         );
      end else begin : g_no_tmr
         assign timer_wave = 1'b0;
      end
   endgenerate

   assign carrier_out = carrier_en & (tmr_mode ? timer_wave : preset_wave);

   // R5: reserved preset never drives the pin
   assert_reserved_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_mode && fmt_sel == 2'b11 && $past(fmt_sel) == 2'b11 && $past(carrier_en)
       && $past(!tmr_mode)) |-> (!preset_wave || $past(preset_wave)));

endmodule

// File: tb/ir_carrier_gen_bench.sv
module ir_carrier_gen_bench;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] fmt_sel = 2'b00;
   logic       carrier_en = 1'b0;
   logic       tmr_mode = 1'b0;
   logic [7:0] tmr_reload = 8'h00;
   logic       carrier_out;

   int n_checks = 0;
   int n_fail = 0;
   string tag = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   ir_carrier_gen u_ir_carrier_gen (
      .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .carrier_en(carrier_en),
      .tmr_mode(tmr_mode), .tmr_reload(tmr_reload), .carrier_out(carrier_out)
   );

   // Behavioural reference
   int m_ph = 0, m_fmt = 0, m_tcnt = 0;
   bit m_pre = 0, m_tog = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_fmt = 0; m_pre = 0; m_tcnt = 0; m_tog = 0;
      end else if (!carrier_en) begin
         m_ph = 0; m_pre = 0; m_tcnt = tmr_reload; m_tog = 0;
      end else begin
         int per, hi;
         if (m_ph == 0) m_fmt = fmt_sel;
         case (m_fmt)
            0: begin per = 12; hi = 4; end
            1: begin per = 12; hi = 6; end
            2: begin per = 8;  hi = 4; end
            default: begin per = 8; hi = 0; end
         endcase
         m_pre = (m_ph < hi);
         m_ph = (m_ph == per - 1) ? 0 : m_ph + 1;
         if (m_tcnt == 255) begin m_tcnt = tmr_reload; m_tog = ~m_tog; end
         else m_tcnt = m_tcnt + 1;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      bit e;
      #1;
      e = carrier_en && (tmr_mode ? m_tog : m_pre);
      check(tag, carrier_out, e);
   end

   task automatic measure(input string req, input int exp_hi, input int exp_lo);
      int hi = 0, lo = 0;
      @(negedge clk); #2;
      while (carrier_out) begin @(negedge clk); #2; end
      while (!carrier_out) begin @(negedge clk); #2; end
      while (carrier_out) begin hi++; @(negedge clk); #2; end
      while (!carrier_out) begin lo++; @(negedge clk); #2; end
      check({req, " high width"}, hi, exp_hi);
      check({req, " low width"}, lo, exp_lo);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      tag = "R1";
      repeat (3) @(negedge clk);
      check("R1 in reset", carrier_out, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 after reset", carrier_out, 0);

      // R2 and first-pulse part of R6
      tag = "R2"; fmt_sel = 2'b00; carrier_en = 1'b1;
      @(negedge clk); #2;
      check("R6 first pulse high", carrier_out, 1);
      measure("R2", 4, 8);

      // R7: change mid period then measure new preset
      tag = "R7";
      @(negedge clk); @(negedge clk);
      fmt_sel = 2'b01;
      repeat (30) @(negedge clk);
      tag = "R3";
      measure("R3", 6, 6);

      tag = "R4"; fmt_sel = 2'b10;
      repeat (14) @(negedge clk);
      measure("R4", 4, 4);

      tag = "R5"; fmt_sel = 2'b11;
      repeat (10) @(negedge clk);
      begin
         int seen = 0;
         for (int i = 0; i < 40; i++) begin @(negedge clk); #2; seen += carrier_out; end
         check("R5 reserved high count", seen, 0);
      end

      // R6: drop enable while high
      tag = "R6"; fmt_sel = 2'b01;
      while (!carrier_out) begin @(negedge clk); #2; end
      carrier_en = 1'b0; #1;
      check("R6 immediate low", carrier_out, 0);
      repeat (5) @(negedge clk);
      carrier_en = 1'b1;
      measure("R6", 6, 6);

      // R8 / R9 timer mode
      carrier_en = 1'b0; tag = "R8";
      @(negedge clk);
      tmr_mode = 1'b1; tmr_reload = 8'hFA; fmt_sel = 2'b11;
      @(negedge clk);
      carrier_en = 1'b1;
      @(negedge clk); #2;
      check("R8 starts low", carrier_out, 0);
      measure("R8", 6, 6);
      tag = "R9"; fmt_sel = 2'b00;
      measure("R9", 6, 6);
      tag = "R8"; tmr_reload = 8'hF0;
      repeat (40) @(negedge clk);
      measure("R8 new reload", 16, 16);

      carrier_en = 1'b0;
      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule